// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits in the receive path of an MPEG transport stream and decides packet by packet what goes downstream. Bytes arrive one per accepted cycle, with a strobe that marks the first byte of each 188-byte packet. The 13-bit packet identifier (PID) is read from the second and third header bytes. That value is compared against a small table of programmable match slots. Two global controls override the table: a pass-all control and a block-all control. A packet leaves the block complete and unchanged, or it does not leave at all.

The decision needs the third header byte, so the stream runs through a three-byte delay line. Each byte leaves the block when the third byte after it in the stream is accepted. Configuration is written into a shadow copy and moves into the working copy only when a new packet starts. A packet whose first byte is not the sync value 0x47 is thrown away and counted. A bit-order control can mirror every output byte of the packets decided while it is set.

Top module: `ts_pid_filter`

## Requirements
- R1: Each forwarded packet appears on the output with its 188 bytes in their original order, and out_start is high with its first byte, which is 0x47 (or 0xE2 when mirrored). A byte leaves one cycle after the third later input byte is accepted. The last three bytes of a packet therefore leave while the first three bytes of the following packet are accepted.
- R2: When bit 16 of slot 0's write word (pass-all) is set in the working configuration, every packet with a correct sync byte is forwarded. Slot contents and block-all have no effect.
- R3: When bit 13 of slot 0's write word (block-all) is set and pass-all is clear, every packet is dropped. Block-all is set out of reset.
- R4: With both global controls clear, the PID is bits 4:0 of header byte 1 followed by all of header byte 2. A packet is forwarded only if some slot has its enable (bit 15) set and its PID field (bits 12:0) equal to that PID. A disabled slot holding the same PID does not forward it.
- R5: A packet whose first byte is not 0x47 is dropped even under pass-all. It raises sync_errs by one, and sync_errs stops at its all-ones value.
- R6: A configuration write first reaches the working copy when the next packet-start byte is accepted after it. A write in the same cycle as a start byte takes effect at the packet after that one. The packet in flight is never affected.
- R7: When bit 14 of slot 0's write word is set in the working configuration, every byte of the packets decided under it leaves with its bit order reversed.
- R8: After reset every slot is disabled with PID 0x1FFF, out_valid is low and sync_errs is zero. A null-PID packet does not pass an unprogrammed table.
- R9: Cycles with in_valid low do not advance the stream. out_valid is high only in the cycle after an accepted input byte.
- R10: cfg_addr selects which of the slots a write updates. The global controls are taken only from writes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_start | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Slot selected by the write |
| cfg_wdata | input | 17 | Slot word: PID 12:0, block-all 13, mirror 14, enable 15, pass-all 16 |
| out_valid | output | 1 | Output byte is present this cycle |
| out_start | output | 1 | Output byte is the first byte of a packet |
| out_data | output | 8 | Output stream byte |
| sync_errs | output | 16 | Saturating count of packets with a bad sync byte |

## Verification
The assertions assume a well-formed input framing. in_start comes only with the first byte of a packet. Each packet is followed by exactly 188 accepted bytes before the next start, in_valid stays low during reset, and cfg_addr stays below the slot count. The bench meets these assumptions because it generates only whole packets from one task, with optional idle gaps and one optional write placed at a chosen byte of the packet. It ends with a packet that has a bad sync byte, so the tail of the previous packet is pushed out.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int          PKT_LEN   = 188;
  localparam int          PID_W     = 13;
  localparam int          WORD_W    = 17;
  localparam logic [7:0]  SYNC_BYTE = 8'h47;
  localparam logic [12:0] NULL_PID  = 13'h1FFF;
  localparam int          B_BLOCK   = 13;
  localparam int          B_MIRROR  = 14;
  localparam int          B_EN      = 15;
  localparam int          B_PASS    = 16;

  typedef struct packed {
    logic             en;
    logic [PID_W-1:0] pid;
  } slot_t;

  typedef struct packed {
    logic pass_all;
    logic block_all;
    logic mirror;
  } glob_t;

  function automatic logic [PID_W-1:0] hdr_pid(input logic [7:0] b1, input logic [7:0] b2);
    return {b1[4:0], b2};
  endfunction

  function automatic logic [7:0] mirror8(input logic [7:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = b[7-k];
    return r;
  endfunction
endpackage

// File: rtl/tsf_cfg_regs.sv
module tsf_cfg_regs
  import tsf_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int AW     = $clog2(NSLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      load,
  output slot_t [NSLOTS-1:0]        act_slots,
  output glob_t                     act_glob
);
  slot_t [NSLOTS-1:0] shd_slots;
  glob_t              shd_glob;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    logic hit_wr;
    assign hit_wr = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_slots[i] <= slot_t'{en: 1'b0, pid: NULL_PID};
        act_slots[i] <= slot_t'{en: 1'b0, pid: NULL_PID};
      end else begin
        if (hit_wr) shd_slots[i] <= slot_t'{en: wr_data[B_EN], pid: wr_data[PID_W-1:0]};
        if (load)   act_slots[i] <= shd_slots[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_glob <= glob_t'{pass_all: 1'b0, block_all: 1'b1, mirror: 1'b0};
      act_glob <= glob_t'{pass_all: 1'b0, block_all: 1'b1, mirror: 1'b0};
    end else begin
      if (wr_en && wr_addr == '0)
        shd_glob <= glob_t'{pass_all: wr_data[B_PASS], block_all: wr_data[B_BLOCK],
                            mirror: wr_data[B_MIRROR]};
      if (load) act_glob <= shd_glob;
    end
  end

  // R6: working configuration only moves on a packet start
  a_r6_hold_midpacket: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_slots) && $stable(act_glob)));
endmodule

// File: rtl/tsf_slot_match.sv
module tsf_slot_match
  import tsf_pkg::*;
#(
  parameter int NSLOTS = 8
) (
  input  slot_t [NSLOTS-1:0] slots,
  input  logic [PID_W-1:0]   pid,
  output logic               hit
);
  logic [NSLOTS-1:0] hit_vec;
  for (genvar i = 0; i < NSLOTS; i++) begin : g_cmp
    assign hit_vec[i] = slots[i].en && (slots[i].pid == pid);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/tsf_delay_line.sv
module tsf_delay_line #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift,
  input  logic       in_first,
  input  logic       in_live,
  input  logic [7:0] in_byte,
  output logic       old_first,
  output logic       old_live,
  output logic [7:0] old_byte,
  output logic [7:0] tap_newest,
  output logic [7:0] tap_second
);
  logic [DEPTH-1:0]      st_first;
  logic [DEPTH-1:0]      st_live;
  logic [DEPTH-1:0][7:0] st_byte;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic       nx_first, nx_live;
    logic [7:0] nx_byte;
    if (s == 0) begin : g_head
      assign nx_first = in_first;
      assign nx_live  = in_live;
      assign nx_byte  = in_byte;
    end else begin : g_body
      assign nx_first = st_first[s-1];
      assign nx_live  = st_live[s-1];
      assign nx_byte  = st_byte[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_first[s] <= 1'b0;
        st_live[s]  <= 1'b0;
        st_byte[s]  <= '0;
      end else if (shift) begin
        st_first[s] <= nx_first;
        st_live[s]  <= nx_live;
        st_byte[s]  <= nx_byte;
      end
    end
  end

  assign old_first  = st_first[DEPTH-1];
  assign old_live   = st_live[DEPTH-1];
  assign old_byte   = st_byte[DEPTH-1];
  assign tap_newest = st_byte[0];
  assign tap_second = st_byte[1];
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import tsf_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [7:0]        in_data,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [16:0]       cfg_wdata,
  output logic              out_valid,
  output logic              out_start,
  output logic [7:0]        out_data,
  output logic [CNT_W-1:0]  sync_errs
);
  localparam int CW = $clog2(PKT_LEN);
  localparam int AW = $clog2(NSLOTS);

  slot_t [NSLOTS-1:0] act_slots;
  glob_t              act_glob;
  logic [CW-1:0]      pos;
  logic               pkt_begin, in_live, decide, sync_ok, slot_hit, pkt_pass;
  logic               pass_q, mirror_q;
  logic               old_first, old_live;
  logic [7:0]         old_byte, hdr_b1, hdr_b0;
  logic [PID_W-1:0]   cur_pid;

  assign pkt_begin = in_valid && in_start;
  assign in_live   = in_start || (pos != '0);
  assign decide    = in_valid && !in_start && (pos == CW'(2));

  tsf_cfg_regs #(.NSLOTS(NSLOTS), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr[AW-1:0]),
    .wr_data(cfg_wdata), .load(pkt_begin),
    .act_slots(act_slots), .act_glob(act_glob));

  tsf_delay_line #(.DEPTH(3)) u_dly (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .in_first(in_start),
    .in_live(in_live), .in_byte(in_data),
    .old_first(old_first), .old_live(old_live), .old_byte(old_byte),
    .tap_newest(hdr_b1), .tap_second(hdr_b0));

  assign cur_pid = hdr_pid(hdr_b1, in_data);

  tsf_slot_match #(.NSLOTS(NSLOTS)) u_match (
    .slots(act_slots), .pid(cur_pid), .hit(slot_hit));

  assign sync_ok  = (hdr_b0 == SYNC_BYTE);
  assign pkt_pass = sync_ok && (act_glob.pass_all || (!act_glob.block_all && slot_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (in_valid) begin
      if (in_start)                    pos <= CW'(1);
      else if (pos == CW'(PKT_LEN-1))  pos <= '0;
      else if (pos != '0)              pos <= pos + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q    <= 1'b0;
      mirror_q  <= 1'b0;
      sync_errs <= '0;
    end else if (decide) begin
      pass_q   <= pkt_pass;
      mirror_q <= act_glob.mirror;
      if (!sync_ok && sync_errs != '1) sync_errs <= sync_errs + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && old_live && pass_q;
      out_start <= in_valid && old_live && pass_q && old_first;
      out_data  <= mirror_q ? mirror8(old_byte) : old_byte;
    end
  end

  // R1: a forwarded packet opens with the sync byte
  a_r1_start_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start) |-> (out_data == SYNC_BYTE || out_data == mirror8(SYNC_BYTE)));
  // R2: pass-all forwards any packet with a good sync byte
  a_r2_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && act_glob.pass_all && sync_ok) |=> pass_q);
  // R3: block-all without pass-all drops
  a_r3_block_all: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && act_glob.block_all && !act_glob.pass_all) |=> !pass_q);
  // R5: a bad sync byte raises the counter by one until it saturates
  a_r5_sync_count: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !sync_ok && sync_errs != '1) |=> (sync_errs == $past(sync_errs) + CNT_W'(1)));
  // R9: output only follows an accepted input byte
  a_r9_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/ts_pid_filter_bench.sv
module ts_pid_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, cfg_we = 1'b0;
  logic [7:0]  in_data = '0;
  logic [2:0]  cfg_addr = '0;
  logic [16:0] cfg_wdata = '0;
  logic        out_valid, out_start;
  logic [7:0]  out_data;
  logic [15:0] sync_errs;

  always #10 clk = ~clk;

  ts_pid_filter u_ts_pid_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_start(out_start), .out_data(out_data), .sync_errs(sync_errs));

  int checks = 0, fails = 0, exp_errs = 0;
  bit    m_en[8];
  int    m_pid[8];
  bit    m_pass, m_block, m_mir;
  byte   q_data[$];
  bit    q_first[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference of the output stream, compared on every clock
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) chk(1'b0, "R3 unexpected byte", int'(out_data), -1);
      else begin
        automatic byte   d = q_data.pop_front();
        automatic bit    f = q_first.pop_front();
        automatic string t = q_tag.pop_front();
        chk(out_data == d && out_start == f, t, {out_start, out_data}, {f, d});
      end
    end
  end

  task automatic model_wr(input int a, input logic [16:0] d);
    m_en[a]  = d[15];
    m_pid[a] = int'(d[12:0]);
    if (a == 0) begin
      m_pass = d[16]; m_block = d[13]; m_mir = d[14];
    end
  endtask

  task automatic cfg_write(input int a, input logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_pkt(input byte s, input int pid, input int seed, input bit gap,
                          input int mid, input int ma, input logic [16:0] md, input string tag);
    byte pk[188];
    bit  go, any;
    // working configuration as seen by this packet: copy of the model at its start
    bit  a_pass = m_pass, a_block = m_block, a_mir = m_mir;
    any = 1'b0;
    for (int k = 0; k < 8; k++) if (m_en[k] && m_pid[k] == pid) any = 1'b1;
    pk[0] = s;
    pk[1] = byte'(8'hA0 | ((pid >> 8) & 31));
    pk[2] = byte'(pid & 255);
    for (int i = 3; i < 188; i++) pk[i] = byte'((seed * 7 + i * 3) & 255);
    go = (s == 8'h47) && (a_pass || (!a_block && any));
    if (s != 8'h47) exp_errs++;
    if (go) for (int i = 0; i < 188; i++) begin
      automatic logic [7:0] b = pk[i];
      q_data.push_back(a_mir ? byte'({<<{b}}) : byte'(b));
      q_first.push_back(i == 0);
      q_tag.push_back(tag);
    end
    for (int i = 0; i < 188; i++) begin
      @(negedge clk);
      if (gap && i > 0 && i % 5 == 0) begin
        in_valid = 1'b0; in_start = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_start = (i == 0); in_data = pk[i];
      if (i == mid) begin
        cfg_we = 1'b1; cfg_addr = 3'(ma); cfg_wdata = md;
        model_wr(ma, md);
      end else cfg_we = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_en[k] = 1'b0; m_pid[k] = 'h1FFF; end
    m_pass = 1'b0; m_block = 1'b1; m_mir = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(sync_errs == 16'd0, "R8 sync_errs", int'(sync_errs), 0);

    send_pkt(8'h47, 'h100, 1, 0, -1, 0, '0, "R3");           // block-all out of reset
    cfg_write(0, 17'h0);
    send_pkt(8'h47, 'h1FFF, 2, 0, -1, 0, '0, "R8");          // null PID, empty table
    cfg_write(3, 17'h08123);
    send_pkt(8'h47, 'h123, 3, 0, -1, 0, '0, "R4");
    send_pkt(8'h47, 'h124, 4, 0, -1, 0, '0, "R4");
    cfg_write(5, 17'h00456);
    send_pkt(8'h47, 'h456, 5, 0, -1, 0, '0, "R4");           // disabled slot
    cfg_write(7, 17'h09ABC);
    send_pkt(8'h47, 'h1ABC, 6, 0, -1, 0, '0, "R10");          // slot 7 addressed
    cfg_write(0, 17'h02000);
    send_pkt(8'h47, 'h123, 7, 0, -1, 0, '0, "R3");
    cfg_write(0, 17'h12000);
    send_pkt(8'h47, 'h777, 8, 0, -1, 0, '0, "R2");
    send_pkt(8'h46, 'h777, 9, 0, -1, 0, '0, "R5");
    chk(sync_errs == 16'(exp_errs), "R5 counter", int'(sync_errs), exp_errs);
    cfg_write(0, 17'h14000);
    send_pkt(8'h47, 'h010, 10, 0, -1, 0, '0, "R7");
    cfg_write(0, 17'h0);
    send_pkt(8'h47, 'h222, 11, 0, 50, 2, 17'h08222, "R6");    // write mid-packet
    send_pkt(8'h47, 'h222, 12, 0, -1, 0, '0, "R6");
    send_pkt(8'h47, 'h123, 13, 0, 0, 3, 17'h01FFF, "R6");     // release with the start byte
    send_pkt(8'h47, 'h123, 14, 0, -1, 0, '0, "R6");
    send_pkt(8'h47, 'h222, 15, 1, -1, 0, '0, "R9");
    send_pkt(8'h00, 'h000, 16, 0, -1, 0, '0, "R5");           // flushes the tail
    repeat (5) @(negedge clk);
    chk(q_data.size() == 0, "R1 bytes left", q_data.size(), 0);
    chk(sync_errs == 16'(exp_errs), "R5 final counter", int'(sync_errs), exp_errs);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule